// File: doc/BRIEF.md
# Memory-to-Memory Move Sequencer

This block carries out the move instructions that copy a byte or a 16-bit word from one memory location to another without touching any register of the processor. The controlling CPU presents an opcode with a one-cycle start pulse. The sequencer then runs a fixed per-opcode program of steps. Each step does one of three things: it takes bytes from the instruction stream, it asks an external address unit to resolve an indexed operand, or it reads the source from memory. The program always closes with exactly one write to the destination.

Three operand forms are supported: immediate data, an extended (absolute 16-bit) address carried in the instruction stream, and an indexed operand. The external address unit resolves indexed operands, and for these moves it is always asked to work in its restricted form. The order of the steps is not always source first. When the source is immediate or extended and the destination is indexed, the destination is resolved before anything about the source is taken from the stream.

Each of the three input channels uses a request/acknowledge handshake. The block holds a request until it sees the one-cycle acknowledge, and it samples the returned value with that acknowledge. The write is a single-cycle strobe. For byte moves, only the low 8 bits of the written data are meaningful.

Top module: `memmove_seq`

## Requirements
- R1: Opcodes 0x08 to 0x0D move a byte and opcodes 0x00 to 0x05 move a word. The opcode's bits 2:0 select the operand form: 0 immediate-to-indexed, 1 extended-to-indexed, 2 indexed-to-indexed, 3 immediate-to-extended, 4 extended-to-extended, 5 indexed-to-extended. Bit 3 set means a byte move.
- R2: Any other opcode ends the instruction the cycle after start, with done and err both high. It issues no request of any kind and no write.
- R3: Immediate-to-extended takes the immediate data from the stream, then the 16-bit destination address from the stream.
- R4: Immediate-to-indexed resolves the destination through the address unit, then takes the immediate data from the stream.
- R5: Extended-to-extended takes the source address from the stream, reads memory at it, then takes the destination address from the stream.
- R6: Extended-to-indexed resolves the destination first, then takes the source address from the stream, then reads memory at it.
- R7: Indexed-to-extended resolves the source, reads memory at it, then takes the destination address from the stream.
- R8: Indexed-to-indexed resolves the source, reads memory at it, then resolves the destination. The first address returned is the source and the second is the destination.
- R9: Every request to the address unit is made with idx_restricted high.
- R10: A legal instruction makes exactly one write, as its last action. The write goes to the destination address, and wr_wide equals the move size. Immediate fetches have fetch_wide equal to the move size. Address fetches and word reads are 16 bits wide, and byte reads have rd_wide low. For byte moves only bits 7:0 of fetch_data or rd_data are used, and wr_data[15:8] is zero.
- R11: busy rises the cycle after an accepted start and stays high through the cycle in which done is high. done is a one-cycle pulse that follows the write by one cycle. A start while busy is high is ignored.
- R12: At most one of fetch_req, idx_req, rd_req and wr_en is high in any cycle. A request stays high, with its width and address unchanged, until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle start of an instruction, accepted while busy is low |
| opcode | input | 8 | Move opcode, sampled with start |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle end-of-instruction pulse |
| err | output | 1 | Illegal opcode, valid with done |
| fetch_req | output | 1 | Request for the next instruction-stream operand |
| fetch_wide | output | 1 | 1: 16-bit operand, 0: 8-bit operand |
| fetch_ack | input | 1 | Stream operand valid |
| fetch_data | input | 16 | Stream operand, big-endian for 16 bits |
| idx_req | output | 1 | Request to resolve an indexed operand |
| idx_restricted | output | 1 | Restricted indexed form requested |
| idx_ack | input | 1 | Resolved address valid |
| idx_addr | input | 16 | Resolved address |
| rd_req | output | 1 | Memory read request for the source |
| rd_wide | output | 1 | 1: 16-bit read, 0: 8-bit read |
| rd_addr | output | 16 | Source address |
| rd_ack | input | 1 | Read data valid |
| rd_data | input | 16 | Read data |
| wr_en | output | 1 | One-cycle write strobe |
| wr_wide | output | 1 | 1: 16-bit write, 0: 8-bit write |
| wr_addr | output | 16 | Destination address |
| wr_data | output | 16 | Write data, byte in bits 7:0 |

## Verification
A wrong step counter or program lookup shows up as the channels being used in the wrong order. Two stream operands or two resolved addresses would then land in each other's registers, so the write would go to the wrong address or carry the wrong data at the end of that same instruction. A latched size or mode that is stale shows at the first request of the next instruction, as a wrong width flag or a wrong channel. A stuck state register shows within one cycle, either as a missing done pulse or as a request while idle. Each channel responder therefore tags its acknowledges in order, and the bench compares that trace with the program expected for the opcode.

// File: rtl/memmove_pkg.sv
`timescale 1ns/1ps
package memmove_pkg;

  // Operand form, equal to opcode bits 2:0
  typedef enum logic [2:0] {
    MD_IMM_IDX = 3'd0,
    MD_EXT_IDX = 3'd1,
    MD_IDX_IDX = 3'd2,
    MD_IMM_EXT = 3'd3,
    MD_EXT_EXT = 3'd4,
    MD_IDX_EXT = 3'd5
  } mode_e;

  typedef enum logic [2:0] {
    STP_IDX_DST,
    STP_IDX_SRC,
    STP_FETCH_DATA,
    STP_FETCH_SADR,
    STP_FETCH_DADR,
    STP_READ,
    STP_WRITE
  } step_e;

  typedef enum logic [1:0] {
    FSM_IDLE,
    FSM_RUN,
    FSM_FIN
  } fsm_e;

  localparam int unsigned PROG_LEN = 4;
  localparam int unsigned PIW      = $clog2(PROG_LEN);
  typedef logic [PIW-1:0] pidx_t;

  // Step k of the program for one operand form; the write ends every program
  function automatic step_e prog_step(mode_e m, pidx_t k);
    step_e s;
    s = STP_WRITE;
    case (m)
      MD_IMM_IDX: case (k)
        2'd0: s = STP_IDX_DST;
        2'd1: s = STP_FETCH_DATA;
        default: s = STP_WRITE;
      endcase
      MD_EXT_IDX: case (k)
        2'd0: s = STP_IDX_DST;
        2'd1: s = STP_FETCH_SADR;
        2'd2: s = STP_READ;
        default: s = STP_WRITE;
      endcase
      MD_IDX_IDX: case (k)
        2'd0: s = STP_IDX_SRC;
        2'd1: s = STP_READ;
        2'd2: s = STP_IDX_DST;
        default: s = STP_WRITE;
      endcase
      MD_IMM_EXT: case (k)
        2'd0: s = STP_FETCH_DATA;
        2'd1: s = STP_FETCH_DADR;
        default: s = STP_WRITE;
      endcase
      MD_EXT_EXT: case (k)
        2'd0: s = STP_FETCH_SADR;
        2'd1: s = STP_READ;
        2'd2: s = STP_FETCH_DADR;
        default: s = STP_WRITE;
      endcase
      MD_IDX_EXT: case (k)
        2'd0: s = STP_IDX_SRC;
        2'd1: s = STP_READ;
        2'd2: s = STP_FETCH_DADR;
        default: s = STP_WRITE;
      endcase
      default: s = STP_WRITE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/memmove_decode.sv
`timescale 1ns/1ps
module memmove_decode
  import memmove_pkg::*;
#(
  parameter int OPW = 8
) (
  input  logic [OPW-1:0] opcode,
  output logic           legal,
  output logic           wide,
  output mode_e          mode
);

  // Byte and word sets share the low three bits; bit 3 picks the size
  assign legal = (opcode[OPW-1:4] == '0) && (opcode[2:0] <= 3'd5);
  assign wide  = ~opcode[3];
  assign mode  = mode_e'(opcode[2:0]);

endmodule

// File: rtl/memmove_ctrl.sv
`timescale 1ns/1ps
module memmove_ctrl
  import memmove_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  logic  op_legal,
  input  logic  op_wide,
  input  mode_e op_mode,
  input  logic  fetch_ack,
  input  logic  rd_ack,
  input  logic  idx_ack,
  output step_e step,
  output logic  adv,
  output logic  size_wide,
  output logic  busy,
  output logic  done,
  output logic  err,
  output logic  fetch_req,
  output logic  fetch_wide,
  output logic  rd_req,
  output logic  idx_req,
  output logic  wr_en
);

  fsm_e  state_q, state_n;
  pidx_t k_q, k_n;
  mode_e mode_q;
  logic  wide_q;
  logic  err_q;
  logic  load;
  logic  run;

  assign load = (state_q == FSM_IDLE) && start;
  assign run  = (state_q == FSM_RUN);
  assign step = prog_step(mode_q, k_q);

  assign fetch_req  = run && ((step == STP_FETCH_DATA) || (step == STP_FETCH_SADR) ||
                              (step == STP_FETCH_DADR));
  assign fetch_wide = (step != STP_FETCH_DATA) || wide_q;
  assign rd_req     = run && (step == STP_READ);
  assign idx_req    = run && ((step == STP_IDX_DST) || (step == STP_IDX_SRC));
  assign wr_en      = run && (step == STP_WRITE);
  assign adv        = (fetch_req && fetch_ack) || (rd_req && rd_ack) || (idx_req && idx_ack);

  assign size_wide = wide_q;
  assign busy      = (state_q != FSM_IDLE);
  assign done      = (state_q == FSM_FIN);
  assign err       = done && err_q;

  always_comb begin
    state_n = state_q;
    k_n     = k_q;
    case (state_q)
      FSM_IDLE: if (start) begin
        state_n = op_legal ? FSM_RUN : FSM_FIN;
        k_n     = '0;
      end
      FSM_RUN: begin
        if (wr_en)    state_n = FSM_FIN;
        else if (adv) k_n     = k_q + 1'b1;
      end
      FSM_FIN:  state_n = FSM_IDLE;
      default:  state_n = FSM_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FSM_IDLE;
      k_q     <= '0;
      mode_q  <= MD_IMM_IDX;
      wide_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      k_q     <= k_n;
      if (load) begin
        mode_q <= op_mode;
        wide_q <= op_wide;
        err_q  <= ~op_legal;
      end
    end
  end

endmodule

// File: rtl/memmove_dp.sv
`timescale 1ns/1ps
module memmove_dp
  import memmove_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  step_e         step,
  input  logic          size_wide,
  input  logic [DW-1:0] fetch_data,
  input  logic [DW-1:0] rd_data,
  input  logic [AW-1:0] idx_addr,
  output logic [AW-1:0] rd_addr,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);

  // Addresses come from the stream at full data width; AW must not exceed DW
  localparam int PADW = DW - BW;

  logic [DW-1:0] sdata_q, sdata_n;
  logic [AW-1:0] saddr_q, saddr_n;
  logic [AW-1:0] daddr_q, daddr_n;

  function automatic logic [DW-1:0] fit(logic wide, logic [DW-1:0] d);
    return wide ? d : {{PADW{1'b0}}, d[BW-1:0]};
  endfunction

  always_comb begin
    sdata_n = sdata_q;
    saddr_n = saddr_q;
    daddr_n = daddr_q;
    if (adv) begin
      case (step)
        STP_IDX_DST:    daddr_n = idx_addr;
        STP_IDX_SRC:    saddr_n = idx_addr;
        STP_FETCH_DATA: sdata_n = fit(size_wide, fetch_data);
        STP_FETCH_SADR: saddr_n = fetch_data[AW-1:0];
        STP_FETCH_DADR: daddr_n = fetch_data[AW-1:0];
        STP_READ:       sdata_n = fit(size_wide, rd_data);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdata_q <= '0;
      saddr_q <= '0;
      daddr_q <= '0;
    end else begin
      sdata_q <= sdata_n;
      saddr_q <= saddr_n;
      daddr_q <= daddr_n;
    end
  end

  assign rd_addr = saddr_q;
  assign wr_addr = daddr_q;
  assign wr_data = sdata_q;

endmodule

// File: rtl/memmove_seq.sv
`timescale 1ns/1ps
module memmove_seq
  import memmove_pkg::*;
#(
  parameter int OPW = 8,
  parameter int AW  = 16,
  parameter int DW  = 16,
  parameter int BW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [OPW-1:0] opcode,
  output logic           busy,
  output logic           done,
  output logic           err,
  output logic           fetch_req,
  output logic           fetch_wide,
  input  logic           fetch_ack,
  input  logic [DW-1:0]  fetch_data,
  output logic           idx_req,
  output logic           idx_restricted,
  input  logic           idx_ack,
  input  logic [AW-1:0]  idx_addr,
  output logic           rd_req,
  output logic           rd_wide,
  output logic [AW-1:0]  rd_addr,
  input  logic           rd_ack,
  input  logic [DW-1:0]  rd_data,
  output logic           wr_en,
  output logic           wr_wide,
  output logic [AW-1:0]  wr_addr,
  output logic [DW-1:0]  wr_data
);

  logic [1:0] rsync_q;
  logic       rst_int_n;
  logic       op_legal, op_wide;
  mode_e      op_mode;
  step_e      step;
  logic       adv;
  logic       size_wide;

  // Reset asserts at once and releases on the second clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  memmove_decode #(.OPW(OPW)) u_dec (
    .opcode (opcode),
    .legal  (op_legal),
    .wide   (op_wide),
    .mode   (op_mode)
  );

  memmove_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start      (start),
    .op_legal   (op_legal),
    .op_wide    (op_wide),
    .op_mode    (op_mode),
    .fetch_ack  (fetch_ack),
    .rd_ack     (rd_ack),
    .idx_ack    (idx_ack),
    .step       (step),
    .adv        (adv),
    .size_wide  (size_wide),
    .busy       (busy),
    .done       (done),
    .err        (err),
    .fetch_req  (fetch_req),
    .fetch_wide (fetch_wide),
    .rd_req     (rd_req),
    .idx_req    (idx_req),
    .wr_en      (wr_en)
  );

  memmove_dp #(.AW(AW), .DW(DW), .BW(BW)) u_dp (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .adv        (adv),
    .step       (step),
    .size_wide  (size_wide),
    .fetch_data (fetch_data),
    .rd_data    (rd_data),
    .idx_addr   (idx_addr),
    .rd_addr    (rd_addr),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data)
  );

  assign idx_restricted = 1'b1;
  assign rd_wide        = size_wide;
  assign wr_wide        = size_wide;

endmodule

// File: rtl/memmove_seq_chk.sv
`timescale 1ns/1ps
module memmove_seq_chk #(
  parameter int OPW = 8,
  parameter int AW  = 16,
  parameter int DW  = 16,
  parameter int BW  = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic [OPW-1:0] opcode,
  input logic           busy,
  input logic           done,
  input logic           err,
  input logic           fetch_req,
  input logic           fetch_wide,
  input logic           fetch_ack,
  input logic           idx_req,
  input logic           idx_ack,
  input logic           rd_req,
  input logic           rd_wide,
  input logic [AW-1:0]  rd_addr,
  input logic           rd_ack,
  input logic           wr_en,
  input logic           wr_wide,
  input logic [DW-1:0]  wr_data
);

  logic op_ok;
  assign op_ok = (opcode[OPW-1:4] == '0) && (opcode[2:0] <= 3'd5);

  p_one_channel_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({fetch_req, idx_req, rd_req, wr_en}) <= 1);

  p_fetch_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req && !fetch_ack |=> fetch_req && $stable(fetch_wide));

  p_read_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack |=> rd_req && $stable(rd_addr) && $stable(rd_wide));

  p_idx_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    idx_req && !idx_ack |=> idx_req);

  p_write_then_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> done && !err);

  p_byte_upper_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_wide |-> wr_data[DW-1:BW] == '0);

  p_illegal_ends_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && !op_ok |=> done && err);

  p_err_with_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  p_legal_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && op_ok |=> busy && !done);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_quiet_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(fetch_req || idx_req || rd_req || wr_en));

endmodule

bind memmove_seq memmove_seq_chk #(.OPW(OPW), .AW(AW), .DW(DW), .BW(BW)) u_chk (.*);

// File: tb/sim_memmove_seq.sv
`timescale 1ns/1ps
module sim_memmove_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic        busy, done, err;
  logic        fetch_req, fetch_wide, fetch_ack = 1'b0;
  logic [15:0] fetch_data = 16'h0000;
  logic        idx_req, idx_restricted, idx_ack = 1'b0;
  logic [15:0] idx_addr = 16'h0000;
  logic        rd_req, rd_wide, rd_ack = 1'b0;
  logic [15:0] rd_addr, rd_data = 16'h0000;
  logic        wr_en, wr_wide;
  logic [15:0] wr_addr, wr_data;

  always #2.5 clk = ~clk;

  memmove_seq u0 (.*);

  int checks = 0;
  int errors = 0;

  logic [15:0] fq[$];
  bit          fwq[$];
  logic [15:0] iq[$];
  bit          exp_rd_wide;
  int unsigned seq;
  int          nwr;
  logic [15:0] wa, wd;
  bit          ww;
  int          fwait = 0, rwait = 0, iwait = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] memval(input logic [15:0] a);
    return {a[7:0] ^ 8'h5A, a[15:8] ^ 8'hC3};
  endfunction

  // Acknowledge trace: idx=1, fetch=2, read=3, two bits per step
  function automatic int unsigned exp_seq(input logic [2:0] m);
    case (m)
      3'd0: return 6;
      3'd1: return 27;
      3'd2: return 29;
      3'd3: return 10;
      3'd4: return 46;
      default: return 30;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] m);
    case (m)
      3'd0: return "R4";
      3'd1: return "R6";
      3'd2: return "R8";
      3'd3: return "R3";
      3'd4: return "R5";
      default: return "R7";
    endcase
  endfunction

  // Stream responder
  always @(negedge clk) begin
    if (fetch_ack) fetch_ack = 1'b0;
    else if (fetch_req) begin
      if (fwait > 0) fwait--;
      else begin
        if (fq.size() == 0) begin
          chk(1'b0, "R12", "unexpected stream fetch", 1, 0);
          fetch_data = 16'h0000;
        end else begin
          chk(fetch_wide == fwq[0], "R10", "fetch width", fetch_wide, fwq[0]);
          fetch_data = fq.pop_front();
          void'(fwq.pop_front());
        end
        seq = seq * 4 + 2;
        fetch_ack = 1'b1;
        fwait = $urandom % 3;
      end
    end
  end

  // Memory read responder
  always @(negedge clk) begin
    if (rd_ack) rd_ack = 1'b0;
    else if (rd_req) begin
      if (rwait > 0) rwait--;
      else begin
        chk(rd_wide == exp_rd_wide, "R10", "read width", rd_wide, exp_rd_wide);
        rd_data = memval(rd_addr);
        seq = seq * 4 + 3;
        rd_ack = 1'b1;
        rwait = $urandom % 3;
      end
    end
  end

  // Address unit responder
  always @(negedge clk) begin
    if (idx_ack) idx_ack = 1'b0;
    else if (idx_req) begin
      if (iwait > 0) iwait--;
      else begin
        chk(idx_restricted == 1'b1, "R9", "restricted flag", idx_restricted, 1);
        if (iq.size() == 0) begin
          chk(1'b0, "R12", "unexpected index request", 1, 0);
          idx_addr = 16'h0000;
        end else idx_addr = iq.pop_front();
        seq = seq * 4 + 1;
        idx_ack = 1'b1;
        iwait = $urandom % 3;
      end
    end
  end

  always @(negedge clk) begin
    if (wr_en) begin
      nwr++;
      wa = wr_addr;
      wd = wr_data;
      ww = wr_wide;
    end
  end

  task automatic run_instr(input logic [7:0] op, input logic [15:0] imm,
                           input logic [15:0] sa, input logic [15:0] da, input bit poke);
    logic [2:0]  m;
    bit          wide, legal;
    logic [15:0] src, expd;
    int          t;
    m     = op[2:0];
    wide  = !op[3];
    legal = (op[7:4] == 4'h0) && (op[2:0] <= 3'd5);
    fq.delete(); fwq.delete(); iq.delete();
    seq = 0; nwr = 0;
    exp_rd_wide = wide;
    src = memval(sa);
    case (m)
      3'd0: begin iq.push_back(da); fq.push_back(imm); fwq.push_back(wide); src = imm; end
      3'd1: begin iq.push_back(da); fq.push_back(sa); fwq.push_back(1'b1); end
      3'd2: begin iq.push_back(sa); iq.push_back(da); end
      3'd3: begin fq.push_back(imm); fwq.push_back(wide); fq.push_back(da); fwq.push_back(1'b1); src = imm; end
      3'd4: begin fq.push_back(sa); fwq.push_back(1'b1); fq.push_back(da); fwq.push_back(1'b1); end
      default: begin iq.push_back(sa); fq.push_back(da); fwq.push_back(1'b1); end
    endcase
    if (!legal) begin fq.delete(); fwq.delete(); iq.delete(); end
    expd = wide ? src : {8'h00, src[7:0]};
    @(negedge clk);
    start = 1'b1; opcode = op;
    @(negedge clk);
    start = 1'b0;
    if (legal) chk(busy == 1'b1, "R11", "busy after start", busy, 1);
    if (poke && legal) begin
      start = 1'b1; opcode = 8'h0C;
      @(negedge clk);
      start = 1'b0;
    end
    t = 0;
    while (!done && t < 300) begin @(negedge clk); t++; end
    chk(done == 1'b1, "R11", "done seen", done, 1);
    chk(err == !legal, legal ? "R1" : "R2", "err flag", err, !legal);
    if (!legal) begin
      chk(t == 0, "R2", "illegal ends after one cycle", t, 0);
      chk(nwr == 0, "R2", "no write", nwr, 0);
      chk(seq == 0, "R2", "no requests", seq, 0);
    end else begin
      chk(nwr == 1, "R10", "write count", nwr, 1);
      chk(seq == exp_seq(m), req_of(m), "channel order", seq, exp_seq(m));
      chk(wa == da, req_of(m), "write address", wa, da);
      chk(wd == expd, "R10", "write data", wd, expd);
      chk(ww == wide, "R1", "write size", ww, wide);
      chk(fq.size() == 0 && iq.size() == 0, req_of(m), "operands consumed",
          fq.size() + iq.size(), 0);
    end
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R11", "done pulse and idle", {done, busy}, 0);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && nwr == (legal ? 1 : 0), "R11", "start while busy ignored",
        nwr, legal ? 1 : 0);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] illegal_ops[5];
    void'($urandom(32'd4242));
    illegal_ops = '{8'h06, 8'h07, 8'h0E, 8'h0F, 8'hA9};
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && wr_en == 0, "R11", "reset outputs", {busy, done, wr_en}, 0);
    chk({fetch_req, idx_req, rd_req} == 0, "R12", "reset requests", {fetch_req, idx_req, rd_req}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int k = 0; k < 6; k++) begin
      run_instr(8'h08 + k[7:0], 16'hBE5A, 16'h1234, 16'hC0DE, k == 2);
      run_instr(8'h00 + k[7:0], 16'h7EA1, 16'hFFFF, 16'h0000, k == 4);
    end
    run_instr(8'h0C, 16'h0000, 16'h0000, 16'hFFFF, 1'b0);
    foreach (illegal_ops[i]) run_instr(illegal_ops[i], 16'h1111, 16'h2222, 16'h3333, 1'b0);
    for (int n = 0; n < 80; n++) begin
      logic [7:0] op;
      if (($urandom % 8) == 0) op = 8'($urandom);
      else op = {4'h0, 1'($urandom), 3'($urandom % 6)};
      run_instr(op, 16'($urandom), 16'($urandom), 16'($urandom), ($urandom % 4) == 0);
    end
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule